// File: doc/BRIEF.md
# Prioritized Exception Entry Sequencer

This block moves a processor from normal execution into exception processing. At each instruction boundary, signalled by a one-cycle `instr_done` pulse, it looks at two sources of requests: the trace bit of the current status word and a leveled hardware interrupt request. If at least one of them is accepted, it captures the status word, the code pointer (segment and offset) and the stack pointer. It then pushes the return context onto the stack through a simple memory port, fetches the handler address from a vector table, and rewrites the status bits. At the end it hands the whole new context back to the core with a single load strobe.

When a trace request and an accepted interrupt are both present, the trace entry is performed first. The interrupt entry follows at once, with no handler instruction and no context load in between. The interrupt entry saves the trace handler's address and the status word already modified by the trace entry. As a result, the interrupt handler runs first and returns into the trace handler, so the debugger sees the next user instruction and never the first instruction of the interrupt handler.

Top module: `exc_entry_seq`

## Requirements
- R1: When a trace request and an accepted interrupt are both present at one boundary, the trace entry (vector 1) is performed first and the interrupt entry follows directly, with `ctx_we_o` pulsing only once, at the end of both.
- R2: Each entry writes three 16-bit words, each at an address 2 below the previous one: first the segment at SP-2, then the offset at SP-4, then the status word at SP-6. The status word is written with its value from before that entry's modification.
- R3: Each entry clears the trace bit (status bit 15) and sets the supervisor bit (status bit 13).
- R4: An interrupt of level L (3 bits, 0 = no request) is accepted only if L is greater than the mask field (status bits 10:8), or if L = 7, which is always accepted. The trace request is taken whenever status bit 15 is set.
- R5: An interrupt entry writes L into the mask field. A trace entry leaves the mask unchanged.
- R6: For vector number V, the handler offset is read from byte address 4·V and the segment from 4·V+2. The trace vector is 1 and the interrupt vector is 24+L. The loaded code pointer is the pair that was read.
- R7: A chained entry pushes the segment and offset of the handler just loaded by the preceding entry, and that entry's modified status word.
- R8: While `mem_valid_o` is high and `mem_ready_i` is low, `mem_valid_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` stay unchanged into the next cycle.
- R9: `busy_o` is high from the cycle after an accepted boundary until the cycle of the single-cycle `ctx_we_o` pulse, and low right after it. `ctx_we_o` presents the final status, segment, offset and a stack pointer lowered by 6 per entry.
- R10: A boundary with no accepted request causes no memory access and `busy_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done | input | 1 | Instruction boundary pulse |
| irq_level_i | input | 3 | Hardware interrupt level, 0 = none |
| sr_i | input | 16 | Current status word |
| seg_i | input | 16 | Current code segment (return address) |
| off_i | input | 16 | Current code offset (return address) |
| sp_i | input | 16 | Current stack pointer (byte address) |
| busy_o | output | 1 | Exception entry in progress |
| ctx_we_o | output | 1 | Load strobe for the new context |
| sr_o | output | 16 | New status word |
| seg_o | output | 16 | Handler segment |
| off_o | output | 16 | Handler offset |
| sp_o | output | 16 | New stack pointer |
| mem_valid_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Memory request is a write |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 16 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts/answers the request |
| mem_rdata_i | input | 16 | Memory read data, valid with ready |

## Verification
The assertions check on every cycle the properties that hold at any point in a run. These are the handshake hold rule, that memory traffic only occurs while busy, that busy drops right after the load strobe, and that every loaded status word has trace cleared and supervisor set. The exact push addresses and values, the order of the vector reads, the chaining of a trace entry into an interrupt entry, and the acceptance rule against the mask (including level 7 against mask 7) depend on the context presented at the boundary. Only the bench's directed scenarios show these, by comparing the logged memory traffic and the loaded context with values computed from the requirements.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PUSH_SEG,
    S_PUSH_OFF,
    S_PUSH_SR,
    S_VEC_LO,
    S_VEC_HI,
    S_DONE
  } seq_state_t;

  localparam int SR_TRACE_BIT = 15;
  localparam int SR_SUPV_BIT  = 13;
  localparam int SR_MASK_LSB  = 8;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int LVLW = 3
) (
  input  logic            trace_bit,
  input  logic [LVLW-1:0] lvl,
  input  logic [LVLW-1:0] mask,
  output logic            acc_trace,
  output logic            acc_irq
);
  localparam logic [LVLW-1:0] TOP_LVL = '1;

  assign acc_trace = trace_bit;
  assign acc_irq   = (lvl != '0) && ((lvl > mask) || (lvl == TOP_LVL));
endmodule

// File: rtl/exc_sr_upd.sv
module exc_sr_upd
  import exc_seq_pkg::*;
#(
  parameter int DW   = 16,
  parameter int LVLW = 3
) (
  input  logic [DW-1:0]   sr_in,
  input  logic            is_irq,
  input  logic [LVLW-1:0] lvl,
  output logic [DW-1:0]   sr_out
);
  always_comb begin
    sr_out               = sr_in;
    sr_out[SR_TRACE_BIT] = 1'b0;
    sr_out[SR_SUPV_BIT]  = 1'b1;
    if (is_irq) sr_out[SR_MASK_LSB +: LVLW] = lvl;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int AW           = 16,
  parameter int DW           = 16,
  parameter int LVLW         = 3,
  parameter int VW           = 8,
  parameter int TRACE_VEC    = 1,
  parameter int IRQ_VEC_BASE = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_done,
  input  logic [LVLW-1:0] irq_level_i,
  input  logic [DW-1:0]   sr_i,
  input  logic [DW-1:0]   seg_i,
  input  logic [DW-1:0]   off_i,
  input  logic [AW-1:0]   sp_i,
  output logic            busy_o,
  output logic            ctx_we_o,
  output logic [DW-1:0]   sr_o,
  output logic [DW-1:0]   seg_o,
  output logic [DW-1:0]   off_o,
  output logic [AW-1:0]   sp_o,
  output logic            mem_valid_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic            mem_ready_i,
  input  logic [DW-1:0]   mem_rdata_i
);
  localparam logic [AW-1:0] WSTEP = AW'(DW / 8);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  seq_state_t      state, state_n;
  logic            pend_trace, pend_trace_n;
  logic            pend_irq, pend_irq_n;
  logic [DW-1:0]   w_sr, w_seg, w_off, lo_buf;
  logic [AW-1:0]   w_sp;
  logic [LVLW-1:0] lvl_q;

  logic acc_trace, acc_irq, cap, fire, apply;
  logic [DW-1:0]   sr_new;
  logic [VW-1:0]   vec_num;
  logic [AW-1:0]   vec_addr;

  exc_arbiter #(.LVLW(LVLW)) arb_i (
    .trace_bit (sr_i[SR_TRACE_BIT]),
    .lvl       (irq_level_i),
    .mask      (sr_i[SR_MASK_LSB +: LVLW]),
    .acc_trace (acc_trace),
    .acc_irq   (acc_irq)
  );

  // the entry in progress is the trace one while trace is still pending
  exc_sr_upd #(.DW(DW), .LVLW(LVLW)) upd_i (
    .sr_in  (w_sr),
    .is_irq (!pend_trace),
    .lvl    (lvl_q),
    .sr_out (sr_new)
  );

  assign cap   = (state == S_IDLE) && instr_done && (acc_trace || acc_irq);
  assign fire  = mem_valid_o && mem_ready_i;
  assign apply = (state == S_VEC_HI) && mem_ready_i;

  assign vec_num  = pend_trace ? VW'(TRACE_VEC) : (VW'(IRQ_VEC_BASE) + VW'(lvl_q));
  assign vec_addr = AW'({vec_num, 2'b00});

  // next state
  always_comb begin
    state_n      = state;
    pend_trace_n = pend_trace;
    pend_irq_n   = pend_irq;
    case (state)
      S_IDLE: if (cap) begin
        state_n      = S_PUSH_SEG;
        pend_trace_n = acc_trace;
        pend_irq_n   = acc_irq;
      end
      S_PUSH_SEG: if (mem_ready_i) state_n = S_PUSH_OFF;
      S_PUSH_OFF: if (mem_ready_i) state_n = S_PUSH_SR;
      S_PUSH_SR:  if (mem_ready_i) state_n = S_VEC_LO;
      S_VEC_LO:   if (mem_ready_i) state_n = S_VEC_HI;
      S_VEC_HI: if (mem_ready_i) begin
        if (pend_trace) pend_trace_n = 1'b0;
        else            pend_irq_n   = 1'b0;
        state_n = (pend_trace && pend_irq) ? S_PUSH_SEG : S_DONE;
      end
      S_DONE:  state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  // memory request
  always_comb begin
    mem_valid_o = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (state)
      S_PUSH_SEG: begin
        mem_valid_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o  = w_sp - WSTEP; mem_wdata_o = w_seg;
      end
      S_PUSH_OFF: begin
        mem_valid_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o  = w_sp - WSTEP; mem_wdata_o = w_off;
      end
      S_PUSH_SR: begin
        mem_valid_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o  = w_sp - WSTEP; mem_wdata_o = w_sr;
      end
      S_VEC_LO: begin
        mem_valid_o = 1'b1; mem_addr_o = vec_addr;
      end
      S_VEC_HI: begin
        mem_valid_o = 1'b1; mem_addr_o = vec_addr + WSTEP;
      end
      default: ;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state      <= S_IDLE;
      pend_trace <= 1'b0;
      pend_irq   <= 1'b0;
    end else begin
      state      <= state_n;
      pend_trace <= pend_trace_n;
      pend_irq   <= pend_irq_n;
    end
  end

  // datapath registers, written only under their enables
  always_ff @(posedge clk) begin
    if (cap) begin
      w_sr  <= sr_i;
      w_seg <= seg_i;
      w_off <= off_i;
      lvl_q <= irq_level_i;
    end else if (apply) begin
      w_sr  <= sr_new;
      w_seg <= mem_rdata_i;
      w_off <= lo_buf;
    end
    if (cap)                       w_sp <= sp_i;
    else if (fire && mem_we_o)     w_sp <= w_sp - WSTEP;
    if ((state == S_VEC_LO) && mem_ready_i) lo_buf <= mem_rdata_i;
  end

  assign busy_o   = (state != S_IDLE);
  assign ctx_we_o = (state == S_DONE);
  assign sr_o     = w_sr;
  assign seg_o    = w_seg;
  assign off_o    = w_off;
  assign sp_o     = w_sp;
endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
  import exc_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          ctx_we_o,
  input logic [DW-1:0] sr_o,
  input logic          mem_valid_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic          mem_ready_i
);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_we_o)
      && $stable(mem_addr_o) && $stable(mem_wdata_o));

  // R9
  traffic_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid_o |-> busy_o);

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_we_o |=> !busy_o && !ctx_we_o);

  // R3
  handler_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_we_o |-> !sr_o[SR_TRACE_BIT] && sr_o[SR_SUPV_BIT]);
endmodule

bind exc_entry_seq exc_seq_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .ctx_we_o    (ctx_we_o),
  .sr_o        (sr_o),
  .mem_valid_o (mem_valid_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i)
);

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_done = 1'b0;
  logic [2:0]  irq_level_i = '0;
  logic [15:0] sr_i = '0, seg_i = '0, off_i = '0, sp_i = '0;
  logic        busy_o, ctx_we_o, mem_valid_o, mem_we_o, mem_ready_i;
  logic [15:0] sr_o, seg_o, off_o, sp_o, mem_addr_o, mem_wdata_o, mem_rdata_i;

  localparam logic [15:0] SEG0 = 16'h3000, OFF0 = 16'h0120, SP0 = 16'h8000;

  int n_chk = 0, n_fail = 0;
  int stall = 0, wcnt = 0, stab_err = 0, strobes = 0;
  int wr_n = 0, rd_n = 0;
  logic [15:0] wa[16], wd[16], ra[16];
  bit hold_pend = 0, fin = 0;
  logic [15:0] h_addr, h_data;
  logic        h_we;

  always #4 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .irq_level_i(irq_level_i),
    .sr_i(sr_i), .seg_i(seg_i), .off_i(off_i), .sp_i(sp_i),
    .busy_o(busy_o), .ctx_we_o(ctx_we_o), .sr_o(sr_o), .seg_o(seg_o),
    .off_o(off_o), .sp_o(sp_o), .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [15:0] rd_val(input logic [15:0] a);
    return {a[7:0], ~a[7:0]};
  endfunction

  assign mem_ready_i = mem_valid_o && (wcnt >= stall);
  assign mem_rdata_i = rd_val(mem_addr_o);

  always @(posedge clk) begin
    if (hold_pend && (!mem_valid_o || mem_addr_o != h_addr ||
                      mem_wdata_o != h_data || mem_we_o != h_we))
      stab_err++;
    hold_pend = mem_valid_o && !mem_ready_i;
    h_addr = mem_addr_o; h_data = mem_wdata_o; h_we = mem_we_o;
    if (mem_valid_o && mem_ready_i) begin
      if (mem_we_o) begin
        if (wr_n < 16) begin wa[wr_n] = mem_addr_o; wd[wr_n] = mem_wdata_o; end
        wr_n++;
      end else begin
        if (rd_n < 16) ra[rd_n] = mem_addr_o;
        rd_n++;
      end
    end
    if (ctx_we_o) strobes++;
    if (mem_valid_o && !mem_ready_i) wcnt <= wcnt + 1;
    else wcnt <= 0;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // one boundary with a given context; expectations built from R1..R10
  task automatic entry_case(input logic [15:0] sr, input logic [2:0] lvl,
                            input int stl, input bit et, input bit ei);
    logic [15:0] e_sr, e_seg, e_off, e_sp, va;
    logic [15:0] xa[16], xd[16], xr[16];
    int nw = 0, nr = 0;
    bit ok = 0;
    e_sr = sr; e_seg = SEG0; e_off = OFF0; e_sp = SP0;
    for (int k = 0; k < 2; k++) begin
      bit is_irq;
      if (k == 0 && !et) continue;
      if (k == 1 && !ei) continue;
      is_irq = (k == 1);
      xa[nw] = e_sp - 2; xd[nw] = e_seg; nw++;
      xa[nw] = e_sp - 4; xd[nw] = e_off; nw++;
      xa[nw] = e_sp - 6; xd[nw] = e_sr;  nw++;
      e_sp = e_sp - 6;
      va = is_irq ? 16'((24 + int'(lvl)) * 4) : 16'd4;
      xr[nr] = va; nr++; xr[nr] = va + 2; nr++;
      e_off = rd_val(va); e_seg = rd_val(va + 2);
      e_sr[15] = 1'b0; e_sr[13] = 1'b1;
      if (is_irq) e_sr[10:8] = lvl;
    end
    @(negedge clk);
    stall = stl; wr_n = 0; rd_n = 0; strobes = 0;
    sr_i = sr; seg_i = SEG0; off_i = OFF0; sp_i = SP0; irq_level_i = lvl;
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
    if (!(et || ei)) begin
      repeat (10) @(negedge clk);
      chk("R10", "busy without request", int'(busy_o), 0);
      chk("R10", "writes without request", wr_n, 0);
      chk("R4", "reads without accepted request", rd_n, 0);
      return;
    end
    chk("R9", "busy after boundary", int'(busy_o), 1);
    for (int c = 0; c < 400 && !ok; c++) begin
      if (ctx_we_o) ok = 1;
      else @(negedge clk);
    end
    chk("R9", "load strobe seen", int'(ok), 1);
    chk("R3", "status after entry", int'(sr_o), int'(e_sr));
    chk("R5", "mask field", int'(sr_o[10:8]), int'(e_sr[10:8]));
    chk("R6", "handler segment", int'(seg_o), int'(e_seg));
    chk("R6", "handler offset", int'(off_o), int'(e_off));
    chk("R9", "stack pointer", int'(sp_o), int'(e_sp));
    chk("R2", "write count", wr_n, nw);
    chk("R6", "read count", rd_n, nr);
    for (int i = 0; i < nw && i < wr_n && i < 16; i++) begin
      chk(i >= 3 ? "R7" : "R2", "push address", int'(wa[i]), int'(xa[i]));
      chk(i >= 3 ? "R7" : "R2", "push data", int'(wd[i]), int'(xd[i]));
    end
    for (int i = 0; i < nr && i < rd_n && i < 16; i++)
      chk(et && ei ? "R1" : "R6", "vector read address", int'(ra[i]), int'(xr[i]));
    @(negedge clk);
    chk("R9", "busy after strobe", int'(busy_o), 0);
    chk("R1", "strobe count", strobes, 1);
  endtask

  task automatic t_reset();
    chk("R9", "reset busy", int'(busy_o), 0);
    chk("R9", "reset strobe", int'(ctx_we_o), 0);
    chk("R10", "reset mem valid", int'(mem_valid_o), 0);
  endtask
  task automatic t_no_request();   entry_case(16'h0000, 3'd0, 0, 0, 0); endtask  // R10
  task automatic t_masked();       entry_case(16'h0300, 3'd3, 0, 0, 0); endtask  // R4 equal level blocked
  task automatic t_irq();          entry_case(16'h0200, 3'd5, 0, 0, 1); endtask  // R4 R5 R6
  task automatic t_top_level();    entry_case(16'h0700, 3'd7, 1, 0, 1); endtask  // R4 level 7 vs mask 7
  task automatic t_trace();        entry_case(16'h8400, 3'd2, 0, 1, 0); endtask  // R3 R5 mask kept
  task automatic t_chain();        entry_case(16'h8100, 3'd6, 2, 1, 1); endtask  // R1 R7 R8
  task automatic t_hold();
    chk("R8", "request changed while stalled", stab_err, 0);
  endtask

  initial begin
    #800000;
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_no_request();
    t_masked();
    t_irq();
    t_top_level();
    t_trace();
    t_chain();
    t_hold();
    fin = 1;
    summary();
    $finish;
  end
endmodule